// File: doc/BRIEF.md
# Primary/Secondary Opcode Instruction Decoder

This block turns one 32-bit instruction word of a small load/store RISC instruction set into the control signals a datapath needs. It is pure combinational logic. A word enters on `instr_i`, and the register numbers, the extended immediate, the instruction class, the selected secondary operation code and the enables all appear in the same cycle.

The instruction set uses a 4-bit primary opcode in the top nibble. Each instruction family leaves a different field free, and that free field carries the secondary operation code. Register-form families carry it in the low bits of the immediate. ALU-immediate, compare-immediate, load and jump carry it in the rt field. Store and branch carry it in the rd field. The decoder picks the field that fits the family, checks that the code is assigned, and raises an illegal flag for anything it does not recognise. An illegal word asserts no class, no secondary code and no enable.

The block has no state, so it has no state machine; its "states" are the decode families. FAM_ALUR, FAM_ALUI, FAM_CMPR, FAM_CMPI, FAM_LOAD, FAM_STORE, FAM_BRANCH and FAM_JUMP are the legal families, and FAM_NONE means an unassigned primary opcode. Each new word simply selects one of these families. There are no transitions between them.

Top module: `instr_decoder`

## Requirements
- R1: `rd_o`, `rs_o` and `rt_o` always equal instruction bits [27:24], [23:20] and [19:16], whatever the opcode or legality.
- R2: `imm_o` is instruction bits [15:0] sign-extended to 32 bits for every word except a legal move-high.
- R3: Move-high is primary 1000 with rt = 1011. When it is legal, `imm_o` = {bits[15:0], 16'h0000}.
- R4: `cls_o` is one-hot for a legal word. Bit 0 is ALU (primary 0000 and 1000), bit 1 is compare (0010 and 1010), bit 2 is load (1001), bit 3 is store (0101), bit 4 is branch (0110) and bit 5 is jump (1011). `cls_o` is all zero when the word is illegal.
- R5: `sub_o` takes bits [3:0] for primary 0000 and 0010. It takes the rt field for 1000, 1010, 1001 and 1011, and the rd field for 0101 and 0110. It is zero when the word is illegal.
- R6: The ALU secondary codes for 0000 and 1000 are 0000 add, 0001 sub, 0100 and, 0101 or, 0110 xor, 1100 nand, 1101 nor and 1110 xnor; 1000 also accepts 1011 move-high. Any other code is illegal.
- R7: The condition codes for 0010, 1010 and 0110 are 0000 false, 0001 eq, 0010 lt, 0011 le, 1000 true, 1001 ne, 1010 ge and 1011 gt. Any other code is illegal.
- R8: Load (1001), store (0101) and jump (1011) accept only secondary code 0000.
- R9: A word with primary 0000 or 0010 and any nonzero bit in [15:4] is illegal.
- R10: A primary opcode outside {0000, 0010, 0101, 0110, 1000, 1001, 1010, 1011} raises `bad_o`.
- R11: `reg_we_o` is high for legal ALU, compare, load and jump words. `mem_re_o` is high only for a legal load, and `mem_we_o` only for a legal store. All three are low when `bad_o` is high.
- R12: `use_imm_o` is high for legal 1000, 1010, 1001, 0101 and 1011 words. It is low for 0000, 0010 and 0110, and low when the word is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 4 | Bits [27:24] |
| rs_o | output | 4 | Bits [23:20] |
| rt_o | output | 4 | Bits [19:16] |
| imm_o | output | 32 | Sign-extended or move-high immediate |
| cls_o | output | 6 | One-hot instruction class |
| sub_o | output | 4 | Secondary operation code taken from the family's field |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| use_imm_o | output | 1 | Second operand comes from the immediate |
| bad_o | output | 1 | Illegal instruction |

## Verification
Every result is due in the same cycle as the word that produces it, because no register lies between `instr_i` and any output. The bench changes the word just after a rising clock edge and compares all outputs at the following falling edge. That leaves half a period for the logic to settle and keeps every comparison clear of the edge at which the next word is applied. A behavioural model in the bench computes the expected outputs from the same word on every clock. Each mismatch is reported under the requirement that the output or the cause of illegality belongs to.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;

    localparam int OPW  = 4;
    localparam int REGW = 4;
    localparam int IMMW = 16;
    localparam int SUBW = 4;
    localparam int CLSW = 6;
    localparam int REGFORM_SUB_LSB = 0;
    localparam int REGFORM_PAD_LSB = SUBW;

    localparam logic [OPW-1:0] OP_ALUR   = 4'b0000;
    localparam logic [OPW-1:0] OP_CMPR   = 4'b0010;
    localparam logic [OPW-1:0] OP_STORE  = 4'b0101;
    localparam logic [OPW-1:0] OP_BRANCH = 4'b0110;
    localparam logic [OPW-1:0] OP_ALUI   = 4'b1000;
    localparam logic [OPW-1:0] OP_LOAD   = 4'b1001;
    localparam logic [OPW-1:0] OP_CMPI   = 4'b1010;
    localparam logic [OPW-1:0] OP_JUMP   = 4'b1011;

    localparam logic [SUBW-1:0] SUB_MOVHI = 4'b1011;
    localparam logic [SUBW-1:0] SUB_ONLY  = 4'b0000;

    localparam int CLS_ALU = 0;
    localparam int CLS_CMP = 1;
    localparam int CLS_LD  = 2;
    localparam int CLS_ST  = 3;
    localparam int CLS_BR  = 4;
    localparam int CLS_JMP = 5;

    typedef enum logic [3:0] {
        FAM_ALUR,
        FAM_ALUI,
        FAM_CMPR,
        FAM_CMPI,
        FAM_LOAD,
        FAM_STORE,
        FAM_BRANCH,
        FAM_JUMP,
        FAM_NONE
    } fam_e;

    typedef enum logic [1:0] {
        SRC_LOWIMM,
        SRC_RT,
        SRC_RD
    } subsrc_e;

    typedef struct packed {
        logic reg_we;
        logic mem_re;
        logic mem_we;
        logic use_imm;
    } ctl_t;

endpackage

// File: rtl/instr_decoder_fields.sv
module instr_decoder_fields
    import instr_decoder_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] word_i,
    output logic [OPW-1:0]  op_o,
    output logic [REGW-1:0] rd_o,
    output logic [REGW-1:0] rs_o,
    output logic [REGW-1:0] rt_o,
    output logic [SUBW-1:0] low_sub_o,
    output logic            pad_zero_o,
    output logic [XLEN-1:0] sext_o,
    output logic [XLEN-1:0] high_o
);
    localparam int OP_LSB = XLEN - OPW;
    localparam int RD_LSB = OP_LSB - REGW;
    localparam int RS_LSB = RD_LSB - REGW;
    localparam int RT_LSB = RS_LSB - REGW;
    localparam int EXTW   = XLEN - IMMW;

    logic [IMMW-1:0] imm16;

    assign op_o      = word_i[OP_LSB +: OPW];
    assign rd_o      = word_i[RD_LSB +: REGW];
    assign rs_o      = word_i[RS_LSB +: REGW];
    assign rt_o      = word_i[RT_LSB +: REGW];
    assign imm16     = word_i[IMMW-1:0];
    assign low_sub_o = imm16[REGFORM_SUB_LSB +: SUBW];
    assign pad_zero_o = (imm16[IMMW-1:REGFORM_PAD_LSB] == '0);

    generate
        if (EXTW > 0) begin : g_wide
            assign sext_o = {{EXTW{imm16[IMMW-1]}}, imm16};
            assign high_o = {imm16, {EXTW{1'b0}}};
        end else begin : g_narrow
            assign sext_o = imm16[XLEN-1:0];
            assign high_o = imm16[XLEN-1:0];
        end
    endgenerate

endmodule

// File: rtl/instr_decoder_family.sv
module instr_decoder_family
    import instr_decoder_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    output fam_e           fam_o
);
    always_comb begin
        unique case (op_i)
            OP_ALUR:   fam_o = FAM_ALUR;
            OP_ALUI:   fam_o = FAM_ALUI;
            OP_CMPR:   fam_o = FAM_CMPR;
            OP_CMPI:   fam_o = FAM_CMPI;
            OP_LOAD:   fam_o = FAM_LOAD;
            OP_STORE:  fam_o = FAM_STORE;
            OP_BRANCH: fam_o = FAM_BRANCH;
            OP_JUMP:   fam_o = FAM_JUMP;
            default:   fam_o = FAM_NONE;
        endcase
    end
endmodule

// File: rtl/instr_decoder_subop.sv
module instr_decoder_subop
    import instr_decoder_pkg::*;
(
    input  fam_e            fam_i,
    input  logic [REGW-1:0] rd_i,
    input  logic [REGW-1:0] rt_i,
    input  logic [SUBW-1:0] low_sub_i,
    input  logic            pad_zero_i,
    output logic [SUBW-1:0] sub_o,
    output logic            legal_o,
    output logic            movhi_o,
    output logic [CLSW-1:0] cls_o,
    output ctl_t            ctl_o
);
    subsrc_e         src;
    logic [SUBW-1:0] code;
    logic            code_ok;
    logic [CLSW-1:0] cls_raw;
    ctl_t            ctl_raw;

    function automatic logic alu_ok(input logic [SUBW-1:0] c, input logic imm_form);
        unique case (c)
            4'b0000, 4'b0001, 4'b0100, 4'b0101,
            4'b0110, 4'b1100, 4'b1101, 4'b1110: alu_ok = 1'b1;
            SUB_MOVHI:                          alu_ok = imm_form;
            default:                            alu_ok = 1'b0;
        endcase
    endfunction

    function automatic logic cond_ok(input logic [SUBW-1:0] c);
        unique case (c)
            4'b0000, 4'b0001, 4'b0010, 4'b0011,
            4'b1000, 4'b1001, 4'b1010, 4'b1011: cond_ok = 1'b1;
            default:                            cond_ok = 1'b0;
        endcase
    endfunction

    // Which field holds the secondary code for each family
    always_comb begin
        unique case (fam_i)
            FAM_ALUR, FAM_CMPR:                      src = SRC_LOWIMM;
            FAM_STORE, FAM_BRANCH:                   src = SRC_RD;
            default:                                 src = SRC_RT;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_LOWIMM: code = low_sub_i;
            SRC_RD:     code = rd_i;
            default:    code = rt_i;
        endcase
    end

    // Per-family legality, class and controls
    always_comb begin
        cls_raw = '0;
        ctl_raw = '0;
        code_ok = 1'b0;
        unique case (fam_i)
            FAM_ALUR: begin
                code_ok          = alu_ok(code, 1'b0) && pad_zero_i;
                cls_raw[CLS_ALU] = 1'b1;
                ctl_raw.reg_we   = 1'b1;
            end
            FAM_ALUI: begin
                code_ok          = alu_ok(code, 1'b1);
                cls_raw[CLS_ALU] = 1'b1;
                ctl_raw.reg_we   = 1'b1;
                ctl_raw.use_imm  = 1'b1;
            end
            FAM_CMPR: begin
                code_ok          = cond_ok(code) && pad_zero_i;
                cls_raw[CLS_CMP] = 1'b1;
                ctl_raw.reg_we   = 1'b1;
            end
            FAM_CMPI: begin
                code_ok          = cond_ok(code);
                cls_raw[CLS_CMP] = 1'b1;
                ctl_raw.reg_we   = 1'b1;
                ctl_raw.use_imm  = 1'b1;
            end
            FAM_LOAD: begin
                code_ok          = (code == SUB_ONLY);
                cls_raw[CLS_LD]  = 1'b1;
                ctl_raw.reg_we   = 1'b1;
                ctl_raw.mem_re   = 1'b1;
                ctl_raw.use_imm  = 1'b1;
            end
            FAM_STORE: begin
                code_ok          = (code == SUB_ONLY);
                cls_raw[CLS_ST]  = 1'b1;
                ctl_raw.mem_we   = 1'b1;
                ctl_raw.use_imm  = 1'b1;
            end
            FAM_BRANCH: begin
                code_ok          = cond_ok(code);
                cls_raw[CLS_BR]  = 1'b1;
            end
            FAM_JUMP: begin
                code_ok          = (code == SUB_ONLY);
                cls_raw[CLS_JMP] = 1'b1;
                ctl_raw.reg_we   = 1'b1;
                ctl_raw.use_imm  = 1'b1;
            end
            default: begin
                code_ok = 1'b0;
            end
        endcase
    end

    assign legal_o = code_ok;
    assign movhi_o = code_ok && (fam_i == FAM_ALUI) && (code == SUB_MOVHI);
    assign sub_o   = code_ok ? code : '0;
    assign cls_o   = code_ok ? cls_raw : '0;
    assign ctl_o   = code_ok ? ctl_raw : '0;

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_decoder_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr_i,
    output logic [REGW-1:0] rd_o,
    output logic [REGW-1:0] rs_o,
    output logic [REGW-1:0] rt_o,
    output logic [XLEN-1:0] imm_o,
    output logic [CLSW-1:0] cls_o,
    output logic [SUBW-1:0] sub_o,
    output logic            reg_we_o,
    output logic            mem_re_o,
    output logic            mem_we_o,
    output logic            use_imm_o,
    output logic            bad_o
);
    logic [OPW-1:0]  op;
    logic [SUBW-1:0] low_sub;
    logic            pad_zero;
    logic [XLEN-1:0] sext_imm;
    logic [XLEN-1:0] high_imm;
    fam_e            fam;
    logic            legal;
    logic            movhi;
    ctl_t            ctl;

    instr_decoder_fields #(.XLEN(XLEN)) u_fields (
        .word_i     (instr_i),
        .op_o       (op),
        .rd_o       (rd_o),
        .rs_o       (rs_o),
        .rt_o       (rt_o),
        .low_sub_o  (low_sub),
        .pad_zero_o (pad_zero),
        .sext_o     (sext_imm),
        .high_o     (high_imm)
    );

    instr_decoder_family u_family (
        .op_i  (op),
        .fam_o (fam)
    );

    instr_decoder_subop u_subop (
        .fam_i      (fam),
        .rd_i       (rd_o),
        .rt_i       (rt_o),
        .low_sub_i  (low_sub),
        .pad_zero_i (pad_zero),
        .sub_o      (sub_o),
        .legal_o    (legal),
        .movhi_o    (movhi),
        .cls_o      (cls_o),
        .ctl_o      (ctl)
    );

    assign imm_o     = movhi ? high_imm : sext_imm;
    assign bad_o     = !legal;
    assign reg_we_o  = ctl.reg_we;
    assign mem_re_o  = ctl.mem_re;
    assign mem_we_o  = ctl.mem_we;
    assign use_imm_o = ctl.use_imm;

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
    input logic [31:0] instr_i,
    input logic [3:0]  rd_o,
    input logic [3:0]  rs_o,
    input logic [3:0]  rt_o,
    input logic [31:0] imm_o,
    input logic [5:0]  cls_o,
    input logic [3:0]  sub_o,
    input logic        reg_we_o,
    input logic        mem_re_o,
    input logic        mem_we_o,
    input logic        use_imm_o,
    input logic        bad_o
);
    always_comb begin
        p_fields_r1: assert ({rd_o, rs_o, rt_o} == instr_i[27:16])
            else $error("register fields differ from word");
        p_class_onehot_r4: assert ($onehot0(cls_o) && (bad_o == (cls_o == 6'd0)))
            else $error("class not one-hot or disagrees with illegal flag");
        p_illegal_quiet_r11: assert (!bad_o || !(reg_we_o || mem_re_o || mem_we_o || use_imm_o || (sub_o != 4'd0)))
            else $error("illegal word left an output active");
        p_mem_excl_r11: assert (!(mem_re_o && mem_we_o) && !(mem_we_o && reg_we_o))
            else $error("conflicting enables");
        p_store_class_r11: assert (mem_we_o == cls_o[3])
            else $error("memory write not tied to store class");
        p_branch_regs_r12: assert (!cls_o[4] || (!use_imm_o && !reg_we_o))
            else $error("branch selected immediate or wrote a register");
        p_imm_low_r2: assert (imm_o[15:0] == instr_i[15:0] || imm_o[15:0] == 16'h0000)
            else $error("immediate low half corrupted");
        p_unassigned_r10: assert (!(instr_i[31:28] inside {4'h1, 4'h3, 4'h4, 4'h7, 4'hC, 4'hD, 4'hE, 4'hF}) || bad_o)
            else $error("unassigned primary accepted");
    end
endmodule

bind instr_decoder instr_decoder_chk u_chk (.*);

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [3:0]  rd, rs, rt, sub;
    logic [31:0] imm;
    logic [5:0]  cls;
    logic        reg_we, mem_re, mem_we, use_imm, bad;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    instr_decoder u_dut (
        .instr_i   (instr),
        .rd_o      (rd),
        .rs_o      (rs),
        .rt_o      (rt),
        .imm_o     (imm),
        .cls_o     (cls),
        .sub_o     (sub),
        .reg_we_o  (reg_we),
        .mem_re_o  (mem_re),
        .mem_we_o  (mem_we),
        .use_imm_o (use_imm),
        .bad_o     (bad)
    );

    // expected values from the behavioural model
    logic [31:0] e_imm;
    logic [5:0]  e_cls;
    logic [3:0]  e_sub;
    logic [3:0]  e_ctl;
    logic        e_bad;
    string       e_tag;

    function automatic bit alu_set(input int c, input bit imm_form);
        return (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 12 || c == 13 || c == 14)
            || (imm_form && c == 11);
    endfunction

    function automatic bit cond_set(input int c);
        return (c <= 3) || (c >= 8 && c <= 11);
    endfunction

    task automatic model(input logic [31:0] w);
        int op, f_rd, f_rt, lo, c, cbit;
        bit ok, padz;
        op = int'(w[31:28]);
        f_rd = int'(w[27:24]);
        f_rt = int'(w[19:16]);
        lo = int'(w[3:0]);
        padz = (w[15:4] == 12'h0);
        ok = 1'b0; c = 0; cbit = 0; e_ctl = 4'b0000; e_tag = "R10";
        // e_ctl bits: {reg_we, mem_re, mem_we, use_imm}
        case (op)
            0:  begin c = lo;   cbit = 0; e_ctl = 4'b1000;
                      ok = padz && alu_set(c, 0); e_tag = padz ? "R6" : "R9"; end
            8:  begin c = f_rt; cbit = 0; e_ctl = 4'b1001; ok = alu_set(c, 1); e_tag = "R6"; end
            2:  begin c = lo;   cbit = 1; e_ctl = 4'b1000;
                      ok = padz && cond_set(c); e_tag = padz ? "R7" : "R9"; end
            10: begin c = f_rt; cbit = 1; e_ctl = 4'b1001; ok = cond_set(c); e_tag = "R7"; end
            9:  begin c = f_rt; cbit = 2; e_ctl = 4'b1101; ok = (c == 0); e_tag = "R8"; end
            5:  begin c = f_rd; cbit = 3; e_ctl = 4'b0011; ok = (c == 0); e_tag = "R8"; end
            6:  begin c = f_rd; cbit = 4; e_ctl = 4'b0000; ok = cond_set(c); e_tag = "R7"; end
            11: begin c = f_rt; cbit = 5; e_ctl = 4'b1001; ok = (c == 0); e_tag = "R8"; end
            default: ok = 1'b0;
        endcase
        e_bad = !ok;
        e_cls = ok ? (6'b1 << cbit) : 6'b0;
        e_sub = ok ? c[3:0] : 4'h0;
        if (!ok) e_ctl = 4'b0000;
        if (ok && op == 8 && c == 11) e_imm = {w[15:0], 16'h0000};
        else e_imm = {{16{w[15]}}, w[15:0]};
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s word=%h actual=%h expected=%h", req, what, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        #1 instr = w;
        model(w);
        @(negedge clk);
        // outputs are combinational: due in the same cycle as the word
        check("R1", "regs", {20'h0, rd, rs, rt}, {20'h0, w[27:16]});
        check((w[31:28] == 4'h8 && !e_bad && e_sub == 4'hB) ? "R3" : "R2", "imm", imm, e_imm);
        check("R4", "class", {26'h0, cls}, {26'h0, e_cls});
        check("R5", "sub", {28'h0, sub}, {28'h0, e_sub});
        check(e_tag, "bad", {31'h0, bad}, {31'h0, e_bad});
        check("R11", "enables", {29'h0, reg_we, mem_re, mem_we}, {29'h0, e_ctl[3:1]});
        check("R12", "use_imm", {31'h0, use_imm}, {31'h0, e_ctl[0]});
    endtask

    initial begin
        // R1 R2 R6 baseline: all-zero word is a legal register add
        apply(32'h0000_0000);
        // R6 register ALU codes, legal and illegal
        for (int c = 0; c < 16; c++) apply({4'h0, 4'h3, 4'h4, 4'h5, 12'h000, c[3:0]});
        // R9 padding bits set in register forms
        apply(32'h0123_0010);
        apply(32'h0123_8001);
        apply(32'h2123_0100);
        // R3 R6 immediate ALU codes including move-high
        for (int c = 0; c < 16; c++) apply({4'h8, 4'h1, 4'h2, c[3:0], 16'h8765});
        apply(32'h812B_FFFF);
        apply(32'h812B_0001);
        // R7 compare/branch condition codes in all three fields
        for (int c = 0; c < 16; c++) begin
            apply({4'h2, 4'h7, 4'h6, 4'h5, 12'h000, c[3:0]});
            apply({4'hA, 4'h7, 4'h6, c[3:0], 16'hFFFC});
            apply({4'h6, c[3:0], 4'h6, 4'h5, 16'h8000});
        end
        // R8 load/store/jump secondary only 0000
        apply(32'h9120_FFF0);
        apply(32'h9121_0004);
        apply(32'h5034_7FFF);
        apply(32'h5134_0000);
        apply(32'hB2F0_0010);
        apply(32'hB2F4_0010);
        // R10 every primary opcode
        for (int p = 0; p < 16; p++) apply({p[3:0], 28'h0000_000});
        // mixed pseudo-random words, biased toward assigned opcodes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 3 != 0) w[15:4] = 12'h0;
            if (i % 5 == 0) w[19:16] = 4'h0;
            apply(w);
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, fails);
            $finish;
        end
    end

endmodule